// File: doc/BRIEF.md
# Monitor Channel Handshake Engine

This block carries the byte-wide monitor channel of a time-division control frame. The channel travels alongside the command/indication bits. Each frame carries one data byte and two active-low flags per direction. The transmit flag (MX) marks a byte offered by the sender. The receive flag (MR) acknowledges a byte taken by the receiver. Bits move once per frame, on a strobe supplied by the frame-sync logic. Whole bytes move only as fast as the two ends complete the handshake, so a byte is usually repeated over several frames.

The engine plays both roles at once. Its transmitter takes bytes from a local producer, places each one on the outgoing channel with MX low, and repeats it until the far end answers with MR low. Its receiver watches the incoming channel, confirms each offered byte, hands it to local logic and answers with its own MR. Both sides treat two or more consecutive quiet frames, with MX and MR both high, as idle. The receiver reports that condition as end of message once a message has carried at least one byte. Decoding of the bytes that arrive is left to the logic behind this block.

Top module: `mon_hs_top`

## Requirements
- R1: Both handshake flags are active low (0 = active, 1 = inactive). After synchronous reset, `up_mx_n` and `up_mr_n` are 1, `up_byte` is all ones, `link_idle` is 0, and `rcv_valid`, `rcv_eom` and `snd_take` are 0.
- R2: The block samples its channel inputs and updates its channel outputs only in a cycle where `frame_tick` is 1. In other cycles, input changes leave `up_byte`, `up_mx_n`, `up_mr_n` and `link_idle` unchanged.
- R3: The transmitter starts a message only after `IDLE_FRAMES` consecutive frames in which its own MX and the incoming MR were both high. It then loads `snd_byte`, drives `up_mx_n` low and pulses `snd_take` for one clock.
- R4: While a byte is outstanding, the transmitter repeats it unchanged in every frame. It takes an incoming MR low as the acknowledge only after it has seen the incoming MR high in an earlier frame of that same byte. A stale acknowledge is therefore ignored, and every byte is sent in at least two frames.
- R5: On an acknowledge with `snd_valid` high, the next byte replaces the current one, `up_mx_n` stays low and `snd_take` pulses. On an acknowledge with `snd_valid` low, `up_mx_n` returns high and `up_byte` returns to all ones, which opens the end-of-message gap.
- R6: The receiver accepts a byte when the incoming MX is low in two consecutive frames carrying the same byte value. It then pulses `rcv_valid` for one clock with the value on `rcv_byte`, and drives `up_mr_n` low.
- R7: The receiver drives `up_mr_n` high again in the first frame where the incoming MX is high, or where the incoming byte differs from the accepted one. A changed byte, or MX low in a single frame only, is accepted only after two matching frames.
- R8: `link_idle` is 1 once the incoming MX and the block's own MR have both been high for `IDLE_FRAMES` consecutive frames. Any frame that breaks the condition clears it.
- R9: `rcv_eom` pulses once, when `link_idle` becomes 1 after at least one byte was accepted since the previous idle. It does not pulse again while idle persists, and it does not pulse when no byte was accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| frame_tick | input | 1 | One-clock strobe per frame; incoming monitor fields are valid during it |
| dn_byte | input | 8 | Incoming monitor byte |
| dn_mx_n | input | 1 | Incoming transmit flag, active low |
| dn_mr_n | input | 1 | Incoming acknowledge flag for this block's transmitter, active low |
| up_byte | output | 8 | Outgoing monitor byte |
| up_mx_n | output | 1 | Outgoing transmit flag, active low |
| up_mr_n | output | 1 | Outgoing acknowledge flag, active low |
| snd_valid | input | 1 | Local producer has a byte for the transmitter |
| snd_byte | input | 8 | Byte offered by the local producer |
| snd_take | output | 1 | One-clock pulse: `snd_byte` was loaded |
| rcv_valid | output | 1 | One-clock pulse: a byte was accepted |
| rcv_byte | output | 8 | Last accepted byte |
| rcv_eom | output | 1 | One-clock pulse: end of message detected |
| link_idle | output | 1 | Incoming direction has been quiet for the idle window |

## Verification
The bench first drives the incoming MR low in the frame right after a byte is loaded. A design that trusted this stale acknowledge would skip a byte or send it only once. The bench then offers a byte that changes while MX stays low, and a single frame of MX low. A receiver that accepted on the first sighting would deliver a corrupted byte or a spurious one. The bench also asks for a new message right after end of message. A transmitter without the quiet hold-off would pull MX low again before the far end could see two idle frames. Other cases check that nothing moves between frame strobes, and that end of message fires exactly once and never after a reset with no data.

// File: rtl/mon_hs_pkg.sv
package mon_hs_pkg;
    parameter int MON_W = 8;

    typedef logic [MON_W-1:0] mon_byte_t;

    localparam mon_byte_t MON_QUIET_BYTE = '1;

    // Incoming fields the receiver uses in one frame
    typedef struct packed {
        mon_byte_t data;
        logic      mx_n;
    } rx_frame_t;

    typedef enum logic {TX_IDLE, TX_SEND} tx_state_t;

    function automatic logic hs_active(input logic flag_n);
        return !flag_n;
    endfunction
endpackage

// File: rtl/mon_idle_det.sv
module mon_idle_det #(
    parameter int FRAMES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic quiet,
    output logic idle_o,
    output logic reached_o
);
    localparam int CW = $clog2(FRAMES + 1);
    localparam logic [CW-1:0] CNT_TOP = CW'(FRAMES);
    localparam logic [CW-1:0] CNT_PRE = CW'(FRAMES - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt       <= '0;
            reached_o <= 1'b0;
        end else begin
            reached_o <= 1'b0;
            if (tick) begin
                if (!quiet) begin
                    cnt <= '0;
                end else if (cnt != CNT_TOP) begin
                    cnt <= cnt + 1'b1;
                    if (cnt == CNT_PRE) reached_o <= 1'b1;
                end
            end
        end
    end

    assign idle_o = (cnt == CNT_TOP);

    assert_reach_is_idle_R8: assert property (@(posedge clk) disable iff (rst)
        reached_o |-> idle_o);
endmodule

// File: rtl/mon_rx.sv
module mon_rx #(
    parameter int IDLE_FRAMES = 2
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   tick,
    input  mon_hs_pkg::rx_frame_t  dn,
    output logic                   mr_n_o,
    output logic                   rcv_valid_o,
    output mon_hs_pkg::mon_byte_t  rcv_byte_o,
    output logic                   rcv_eom_o,
    output logic                   link_idle_o
);
    import mon_hs_pkg::*;

    mon_byte_t prev_data;
    logic      prev_mx;
    logic      held;
    logic      msg_open;
    logic      mx_now;
    logic      confirm;
    logic      quiet;
    logic      reached;

    assign mx_now  = hs_active(dn.mx_n);
    assign confirm = mx_now && prev_mx && (dn.data == prev_data);
    assign quiet   = !mx_now && !held;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_data   <= MON_QUIET_BYTE;
            prev_mx     <= 1'b0;
            held        <= 1'b0;
            rcv_byte_o  <= MON_QUIET_BYTE;
            rcv_valid_o <= 1'b0;
            msg_open    <= 1'b0;
        end else begin
            rcv_valid_o <= 1'b0;
            if (rcv_eom_o) msg_open <= 1'b0;
            if (tick) begin
                prev_data <= dn.data;
                prev_mx   <= mx_now;
                if (held) begin
                    if (!mx_now || dn.data != rcv_byte_o) held <= 1'b0;
                end else if (confirm) begin
                    held        <= 1'b1;
                    rcv_byte_o  <= dn.data;
                    rcv_valid_o <= 1'b1;
                    msg_open    <= 1'b1;
                end
            end
        end
    end

    mon_idle_det #(.FRAMES(IDLE_FRAMES)) idle_i (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .quiet     (quiet),
        .idle_o    (link_idle_o),
        .reached_o (reached)
    );

    assign mr_n_o    = !held;
    assign rcv_eom_o = reached && msg_open;

    assert_mr_fall_on_tick_R2: assert property (@(posedge clk) disable iff (rst)
        $fell(mr_n_o) |-> $past(tick));
    assert_mr_rise_on_tick_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(mr_n_o) |-> $past(tick));
    assert_accept_acks_R6: assert property (@(posedge clk) disable iff (rst)
        rcv_valid_o |-> !mr_n_o);
    assert_eom_when_idle_R9: assert property (@(posedge clk) disable iff (rst)
        rcv_eom_o |-> link_idle_o);
endmodule

// File: rtl/mon_tx.sv
module mon_tx #(
    parameter int IDLE_FRAMES = 2
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  tick,
    input  logic                  far_mr_n,
    input  logic                  snd_valid,
    input  mon_hs_pkg::mon_byte_t snd_byte,
    output logic                  mx_n_o,
    output mon_hs_pkg::mon_byte_t byte_o,
    output logic                  take_o
);
    import mon_hs_pkg::*;

    tx_state_t state;
    logic      seen_release;
    logic      start_ok;
    logic      hold_reached;
    logic      ack;
    logic      quiet;

    assign quiet = (state == TX_IDLE) && !hs_active(far_mr_n);
    assign ack   = hs_active(far_mr_n) && seen_release;

    mon_idle_det #(.FRAMES(IDLE_FRAMES)) hold_i (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .quiet     (quiet),
        .idle_o    (start_ok),
        .reached_o (hold_reached)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state        <= TX_IDLE;
            byte_o       <= MON_QUIET_BYTE;
            seen_release <= 1'b0;
            take_o       <= 1'b0;
        end else begin
            take_o <= 1'b0;
            if (tick) begin
                unique case (state)
                    TX_IDLE: begin
                        if (snd_valid && start_ok) begin
                            state        <= TX_SEND;
                            byte_o       <= snd_byte;
                            seen_release <= 1'b0;
                            take_o       <= 1'b1;
                        end
                    end
                    TX_SEND: begin
                        if (ack) begin
                            seen_release <= 1'b0;
                            if (snd_valid) begin
                                byte_o <= snd_byte;
                                take_o <= 1'b1;
                            end else begin
                                state  <= TX_IDLE;
                                byte_o <= MON_QUIET_BYTE;
                            end
                        end else if (!hs_active(far_mr_n)) begin
                            seen_release <= 1'b1;
                        end
                    end
                    default: state <= TX_IDLE;
                endcase
            end
        end
    end

    assign mx_n_o = (state != TX_SEND);

    assert_take_with_mx_R3: assert property (@(posedge clk) disable iff (rst)
        take_o |-> !mx_n_o);
    assert_start_after_quiet_R3: assert property (@(posedge clk) disable iff (rst)
        $fell(mx_n_o) |-> $past(start_ok));
    assert_hold_window_idle_R3: assert property (@(posedge clk) disable iff (rst)
        hold_reached |-> mx_n_o);
    assert_byte_held_R4: assert property (@(posedge clk) disable iff (rst)
        (!mx_n_o && !$past(tick)) |-> $stable(byte_o));
endmodule

// File: rtl/mon_hs_top.sv
module mon_hs_top #(
    parameter int IDLE_FRAMES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       frame_tick,
    input  logic [7:0] dn_byte,
    input  logic       dn_mx_n,
    input  logic       dn_mr_n,
    output logic [7:0] up_byte,
    output logic       up_mx_n,
    output logic       up_mr_n,
    input  logic       snd_valid,
    input  logic [7:0] snd_byte,
    output logic       snd_take,
    output logic       rcv_valid,
    output logic [7:0] rcv_byte,
    output logic       rcv_eom,
    output logic       link_idle
);
    import mon_hs_pkg::*;

    rx_frame_t dn_frame;

    assign dn_frame.data = dn_byte;
    assign dn_frame.mx_n = dn_mx_n;

    mon_rx #(.IDLE_FRAMES(IDLE_FRAMES)) rx_i (
        .clk         (clk),
        .rst         (rst),
        .tick        (frame_tick),
        .dn          (dn_frame),
        .mr_n_o      (up_mr_n),
        .rcv_valid_o (rcv_valid),
        .rcv_byte_o  (rcv_byte),
        .rcv_eom_o   (rcv_eom),
        .link_idle_o (link_idle)
    );

    mon_tx #(.IDLE_FRAMES(IDLE_FRAMES)) tx_i (
        .clk       (clk),
        .rst       (rst),
        .tick      (frame_tick),
        .far_mr_n  (dn_mr_n),
        .snd_valid (snd_valid),
        .snd_byte  (snd_byte),
        .mx_n_o    (up_mx_n),
        .byte_o    (up_byte),
        .take_o    (snd_take)
    );
endmodule

// File: tb/mon_hs_tb_top.sv
module mon_hs_tb_top;
    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic       rst = 1'b1;
    logic       frame_tick = 1'b0;
    logic [7:0] dn_byte = 8'hFF;
    logic       dn_mx_n = 1'b1;
    logic       dn_mr_n = 1'b1;
    logic       snd_valid = 1'b0;
    logic [7:0] snd_byte = 8'h00;
    logic [7:0] up_byte, rcv_byte;
    logic       up_mx_n, up_mr_n, snd_take, rcv_valid, rcv_eom, link_idle;

    mon_hs_top dut_i (
        .clk(clk), .rst(rst), .frame_tick(frame_tick),
        .dn_byte(dn_byte), .dn_mx_n(dn_mx_n), .dn_mr_n(dn_mr_n),
        .up_byte(up_byte), .up_mx_n(up_mx_n), .up_mr_n(up_mr_n),
        .snd_valid(snd_valid), .snd_byte(snd_byte), .snd_take(snd_take),
        .rcv_valid(rcv_valid), .rcv_byte(rcv_byte), .rcv_eom(rcv_eom),
        .link_idle(link_idle)
    );

    int n_chk = 0;
    int n_bad = 0;
    logic clr = 1'b0;
    logic rv_seen = 1'b0, eom_seen = 1'b0, take_seen = 1'b0;
    logic [7:0] got_byte = 8'h00;

    always @(posedge clk) begin
        if (clr) begin
            rv_seen <= 1'b0; eom_seen <= 1'b0; take_seen <= 1'b0;
        end else begin
            if (rcv_valid) begin rv_seen <= 1'b1; got_byte <= rcv_byte; end
            if (rcv_eom)   eom_seen  <= 1'b1;
            if (snd_take)  take_seen <= 1'b1;
        end
    end

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    // One frame: present inputs, strobe, let pulses settle
    task automatic frame(input logic [7:0] db, input logic mx, input logic mr,
                         input logic sv, input logic [7:0] sb);
        @(negedge clk);
        dn_byte = db; dn_mx_n = mx; dn_mr_n = mr; snd_valid = sv; snd_byte = sb;
        clr = 1'b1; frame_tick = 1'b1;
        @(negedge clk);
        clr = 1'b0; frame_tick = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    // Stimulus {dn_byte, dn_mx_n, dn_mr_n, snd_valid, snd_byte} then
    // expected {up_byte, up_mx_n, up_mr_n, take, rcv_valid, rcv_byte, eom, idle}
    localparam int NV = 17;
    localparam logic [40:0] VEC [NV] = '{
        {8'hFF,1'b1,1'b1,1'b1,8'hA5, 8'hFF,1'b1,1'b1,1'b0,1'b0,8'h00,1'b0,1'b0},
        {8'h11,1'b0,1'b1,1'b1,8'hA5, 8'hFF,1'b1,1'b1,1'b0,1'b0,8'h00,1'b0,1'b0},
        {8'h11,1'b0,1'b1,1'b1,8'hA5, 8'hA5,1'b0,1'b0,1'b1,1'b1,8'h11,1'b0,1'b0},
        {8'h11,1'b0,1'b0,1'b0,8'h00, 8'hA5,1'b0,1'b0,1'b0,1'b0,8'h00,1'b0,1'b0},
        {8'h22,1'b0,1'b1,1'b0,8'h00, 8'hA5,1'b0,1'b1,1'b0,1'b0,8'h00,1'b0,1'b0},
        {8'h22,1'b0,1'b0,1'b1,8'h3C, 8'h3C,1'b0,1'b0,1'b1,1'b1,8'h22,1'b0,1'b0},
        {8'h33,1'b0,1'b0,1'b0,8'h00, 8'h3C,1'b0,1'b1,1'b0,1'b0,8'h00,1'b0,1'b0},
        {8'h44,1'b0,1'b1,1'b0,8'h00, 8'h3C,1'b0,1'b1,1'b0,1'b0,8'h00,1'b0,1'b0},
        {8'h44,1'b0,1'b0,1'b0,8'h00, 8'hFF,1'b1,1'b0,1'b0,1'b1,8'h44,1'b0,1'b0},
        {8'hFF,1'b1,1'b1,1'b1,8'h77, 8'hFF,1'b1,1'b1,1'b0,1'b0,8'h00,1'b0,1'b0},
        {8'hFF,1'b1,1'b1,1'b1,8'h77, 8'hFF,1'b1,1'b1,1'b0,1'b0,8'h00,1'b0,1'b0},
        {8'hFF,1'b1,1'b1,1'b1,8'h77, 8'h77,1'b0,1'b1,1'b1,1'b0,8'h00,1'b1,1'b1},
        {8'hFF,1'b1,1'b1,1'b0,8'h00, 8'h77,1'b0,1'b1,1'b0,1'b0,8'h00,1'b0,1'b1},
        {8'h55,1'b0,1'b0,1'b0,8'h00, 8'hFF,1'b1,1'b1,1'b0,1'b0,8'h00,1'b0,1'b0},
        {8'h55,1'b1,1'b1,1'b0,8'h00, 8'hFF,1'b1,1'b1,1'b0,1'b0,8'h00,1'b0,1'b0},
        {8'h55,1'b0,1'b1,1'b0,8'h00, 8'hFF,1'b1,1'b1,1'b0,1'b0,8'h00,1'b0,1'b0},
        {8'h55,1'b0,1'b1,1'b0,8'h00, 8'hFF,1'b1,1'b0,1'b0,1'b1,8'h55,1'b0,1'b0}
    };

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 up_byte", up_byte, 8'hFF);
        check("R1 up_mx_n", {7'd0, up_mx_n}, 8'd1);
        check("R1 up_mr_n", {7'd0, up_mr_n}, 8'd1);
        check("R1 link_idle", {7'd0, link_idle}, 8'd0);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            logic [40:0] v;
            v = VEC[i];
            frame(v[40:33], v[32], v[31], v[30], v[29:22]);
            check($sformatf("R4/R5 up_byte frame %0d", i + 1), up_byte, v[21:14]);
            check($sformatf("R3/R5 up_mx_n frame %0d", i + 1), {7'd0, up_mx_n}, {7'd0, v[13]});
            check($sformatf("R6/R7 up_mr_n frame %0d", i + 1), {7'd0, up_mr_n}, {7'd0, v[12]});
            check($sformatf("R3/R5 snd_take frame %0d", i + 1), {7'd0, take_seen}, {7'd0, v[11]});
            check($sformatf("R6 rcv_valid frame %0d", i + 1), {7'd0, rv_seen}, {7'd0, v[10]});
            if (v[10]) check($sformatf("R6 rcv_byte frame %0d", i + 1), got_byte, v[9:2]);
            check($sformatf("R9 rcv_eom frame %0d", i + 1), {7'd0, eom_seen}, {7'd0, v[1]});
            check($sformatf("R8 link_idle frame %0d", i + 1), {7'd0, link_idle}, {7'd0, v[0]});
        end

        // R2: inputs move without a strobe; nothing changes
        @(negedge clk);
        clr = 1'b1;
        dn_byte = 8'hAA; dn_mx_n = 1'b1; dn_mr_n = 1'b0; snd_valid = 1'b1; snd_byte = 8'h99;
        @(negedge clk);
        clr = 1'b0;
        repeat (5) @(negedge clk);
        check("R2 up_mr_n held", {7'd0, up_mr_n}, 8'd0);
        check("R2 up_mx_n held", {7'd0, up_mx_n}, 8'd1);
        check("R2 up_byte held", up_byte, 8'hFF);
        check("R2 no pulses", {5'd0, rv_seen, take_seen, eom_seen}, 8'd0);

        // R7: MX high releases the acknowledge
        frame(8'hAA, 1'b1, 1'b1, 1'b0, 8'h00);
        check("R7 release on mx high", {7'd0, up_mr_n}, 8'd1);

        // R1 reset mid-run, then R3 hold-off and R9 no eom without data
        @(negedge clk); rst = 1'b1;
        repeat (2) @(negedge clk);
        check("R1 up_mr_n after reset", {7'd0, up_mr_n}, 8'd1);
        check("R1 up_mx_n after reset", {7'd0, up_mx_n}, 8'd1);
        check("R1 eom after reset", {7'd0, rcv_eom}, 8'd0);
        rst = 1'b0;
        frame(8'hFF, 1'b1, 1'b1, 1'b1, 8'h5A);
        check("R3 no start frame 1", {7'd0, take_seen}, 8'd0);
        frame(8'hFF, 1'b1, 1'b1, 1'b1, 8'h5A);
        check("R3 no start frame 2", {6'd0, take_seen, up_mx_n}, 8'd1);
        check("R8 idle after window", {7'd0, link_idle}, 8'd1);
        check("R9 no eom without byte", {7'd0, eom_seen}, 8'd0);
        frame(8'hFF, 1'b1, 1'b1, 1'b1, 8'h5A);
        check("R3 start frame 3", {6'd0, take_seen, up_mx_n}, 8'd2);
        check("R3 start byte", up_byte, 8'h5A);

        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule